// File: doc/BRIEF.md
# Banked Memory Map Controller

This block sits between an 8-bit CPU with a 16-bit address bus and its ROM, RAM and keyboard input port. A write-only control register is loaded from a CPU I/O write strobe. It holds four bits: a video enable, a low-window bank select, a top-window bank select and a cassette output level. The block decodes every CPU memory access against the current bank state and drives the chip selects and write enables that follow from it.

The low 16 KB window shows either ROM with writes blocked, or RAM that can be read and written. The top 8 KB window shows either RAM, or a read-only keyboard port. That port reads one row of the key matrix, chosen by the low address bits, and places the cassette input polarity in its most significant bit. Everything between the two windows is RAM in every bank state. The control register updates on the clock edge. All decode and read-data logic is combinational from the stored register and the current bus inputs.

Top module: `mmap_ctrl`

## Requirements
- R1: A control write (`io_wr` high at a rising clock edge) loads `io_wdata` into the register, with bit 0 as video enable, bit 1 as low-window select, bit 2 as top-window select and bit 3 as cassette output. The new setting shows on the outputs only after that edge, not before it.
- R2: With bit 1 clear, a read in 0x0000–0x3FFF asserts `rom_cs` with `rom_addr` equal to address bits [13:0]. A write there asserts neither `ram_cs` nor `ram_we`.
- R3: With bit 1 set, a read or write in 0x0000–0x3FFF asserts `ram_cs` with `ram_addr` equal to the CPU address, and `ram_we` follows the write strobe.
- R4: Any access in 0x4000–0xDFFF asserts `ram_cs` with `ram_addr` equal to the CPU address, and `ram_we` on writes, whatever the bank bits hold.
- R5: With bit 2 clear, an access in 0xE000–0xFFFF is a RAM access at the same address, and `ram_we` is asserted on writes.
- R6: With bit 2 set, a read in 0xE000–0xFFFF asserts `kbd_sel`. A write there asserts neither `ram_cs` nor `ram_we`.
- R7: `kbd_rdata` takes row index `mem_addr[3:0]`. For rows 0–9, bits [4:0] hold that row's 5-bit key vector from `key_rows[5*row +: 5]`, and bits [6:5] are 0. For row indices 10–15, bits [6:0] read 0x1F.
- R8: `kbd_rdata[7]` is 1 when `cas_in_neg` is 1, and 0 otherwise.
- R9: A synchronous reset (`rst_n` low at a clock edge) clears all four control bits. After reset, a low read selects ROM, a top access selects RAM, and `video_en` and `cas_out_neg` are 0.
- R10: `cas_out_neg` is 1 (negative output level) exactly when register bit 3 is 1. `video_en` follows register bit 0.
- R11: At most one of `rom_cs`, `ram_cs` and `kbd_sel` is high at any time. None of them is high when neither `mem_rd` nor `mem_wr` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Control register write strobe |
| io_wdata | input | 8 | Control register write data |
| mem_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | CPU memory read strobe |
| mem_wr | input | 1 | CPU memory write strobe |
| key_rows | input | 50 | Ten 5-bit active-high key row vectors, row r at bits [5r+4:5r] |
| cas_in_neg | input | 1 | Cassette input is below zero |
| rom_cs | output | 1 | ROM chip select |
| rom_addr | output | 14 | ROM address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address |
| kbd_sel | output | 1 | Keyboard port read select |
| kbd_rdata | output | 8 | Keyboard port read data |
| video_en | output | 1 | Video enable |
| cas_out_neg | output | 1 | Cassette output at negative level |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 16 KB low window, an 8 KB top window and ten 5-bit key rows. This configuration is small enough to sweep in full. All four combinations of the bank bits are crossed with every 4 KB address slice and with idle, read and write cycles. All sixteen row indices are checked against both cassette polarities. The sweep therefore reaches both window boundaries, the unused row codes 10–15, the write-blocking cases for ROM and for the keyboard port, and the single cycle between a control write being presented and taking effect.

// File: rtl/mmap_pkg.sv
// Package: shared types for the banked memory map controller.
// Holds the control register layout and the address region encoding.
package mmap_pkg;

    // Bit positions of the control register fields (CPU-visible layout)
    localparam int CTRL_VIDEO_BIT = 0;
    localparam int CTRL_LOW_BIT   = 1;
    localparam int CTRL_TOP_BIT   = 2;
    localparam int CTRL_CAS_BIT   = 3;
    localparam int CTRL_W         = 4;

    // Stored control state
    typedef struct packed {
        logic cas_neg;   // cassette output at negative level
        logic top_kbd;   // top window shows keyboard port
        logic low_ram;   // low window shows RAM
        logic video;     // video enable
    } ctrl_t;

    // Address region of a CPU access
    typedef enum logic [1:0] {
        REG_LOW = 2'd0,
        REG_MID = 2'd1,
        REG_TOP = 2'd2
    } region_e;

endpackage

// File: rtl/mmap_ctrl_reg.sv
// Module: mmap_ctrl_reg
// Write-only control register. It is loaded on a clock edge with the write
// strobe high and cleared by synchronous active-low reset.
// Assumes DATA_W covers every field position defined in mmap_pkg.
module mmap_ctrl_reg
    import mmap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q
);

    ctrl_t ctrl_d;

    // Unpack the written byte into register fields
    always_comb begin
        ctrl_d.video   = wdata[CTRL_VIDEO_BIT];
        ctrl_d.low_ram = wdata[CTRL_LOW_BIT];
        ctrl_d.top_kbd = wdata[CTRL_TOP_BIT];
        ctrl_d.cas_neg = wdata[CTRL_CAS_BIT];
    end

    // Hold the control state; reset clears every field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/mmap_region_dec.sv
// Module: mmap_region_dec
// Classifies a CPU address as low window, middle RAM or top window.
// It sees only the address bits above the top window size. Assumes that
// the low window is larger than the top window.
module mmap_region_dec
    import mmap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LOW_WIN_AW = 14,
    parameter int TOP_WIN_AW = 13
) (
    input  logic [ADDR_W-TOP_WIN_AW-1:0] addr_hi,
    output region_e                      region
);

    localparam int HI_W     = ADDR_W - TOP_WIN_AW;
    localparam int LOW_TAGW = ADDR_W - LOW_WIN_AW;

    logic in_low;
    logic in_top;

    // Window hits: low window has all tag bits clear, top window all set
    always_comb begin
        in_low = ~|addr_hi[HI_W-1 -: LOW_TAGW];
        in_top = &addr_hi;
    end

    // Region priority: top window, then low window, else middle RAM
    always_comb begin
        if (in_top) begin
            region = REG_TOP;
        end else if (in_low) begin
            region = REG_LOW;
        end else begin
            region = REG_MID;
        end
    end

endmodule

// File: rtl/mmap_sel.sv
// Module: mmap_sel
// Drives the ROM, RAM and keyboard port selects from the access region,
// the bank bits and the bus strobes. It is purely combinational.
// Assumes that read and write are never asserted together.
module mmap_sel
    import mmap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROM_AW = 14
) (
    input  region_e           region,
    input  logic              low_ram,
    input  logic              top_kbd,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              kbd_sel
);

    logic access;

    // Any bus cycle in progress
    always_comb access = rd | wr;

    // Address passthrough: RAM sees the CPU address, ROM its low bits
    always_comb begin
        ram_addr = addr;
        rom_addr = addr[ROM_AW-1:0];
    end

    // Per-region target choice
    always_comb begin
        rom_cs  = 1'b0;
        ram_cs  = 1'b0;
        ram_we  = 1'b0;
        kbd_sel = 1'b0;
        unique case (region)
            REG_LOW: begin
                if (low_ram) begin
                    ram_cs = access;
                    ram_we = wr;
                end else begin
                    rom_cs = rd;
                end
            end
            REG_TOP: begin
                if (top_kbd) begin
                    kbd_sel = rd;
                end else begin
                    ram_cs = access;
                    ram_we = wr;
                end
            end
            default: begin
                ram_cs = access;
                ram_we = wr;
            end
        endcase
    end

endmodule

// File: rtl/mmap_kbd_port.sv
// Module: mmap_kbd_port
// Keyboard port read data. A row index picks one key row vector. Indices
// past the last row return a fixed all-ones pattern. The cassette input
// polarity takes the top bit, and the bits in between read zero.
// Assumes KEY_W + 1 <= DATA_W and that KEY_ROWS fits in ROW_IDX_W bits.
module mmap_kbd_port #(
    parameter int KEY_ROWS  = 10,
    parameter int KEY_W     = 5,
    parameter int ROW_IDX_W = 4,
    parameter int DATA_W    = 8
) (
    input  logic [ROW_IDX_W-1:0]      row_idx,
    input  logic [KEY_ROWS*KEY_W-1:0] key_rows,
    input  logic                      cas_in_neg,
    output logic [DATA_W-1:0]         rdata
);

    localparam int PAD_W = DATA_W - 1 - KEY_W;

    logic [KEY_W-1:0] row_arr [KEY_ROWS];
    logic [KEY_W-1:0] row_val;

    // Split the flat row bus into one vector per row
    for (genvar g = 0; g < KEY_ROWS; g++) begin : g_row
        assign row_arr[g] = key_rows[g*KEY_W +: KEY_W];
    end

    // Row mux; an index with no row returns all ones
    always_comb begin
        row_val = '1;
        for (int i = 0; i < KEY_ROWS; i++) begin
            if (row_idx == ROW_IDX_W'(i)) begin
                row_val = row_arr[i];
            end
        end
    end

    // Assemble the port byte
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb rdata = {cas_in_neg, {PAD_W{1'b0}}, row_val};
        end else begin : g_nopad
            always_comb rdata = {cas_in_neg, row_val};
        end
    endgenerate

endmodule

// File: rtl/mmap_ctrl.sv
// Module: mmap_ctrl (top)
// Banked memory map controller for an 8-bit CPU. It holds the control
// register and decodes each memory access to ROM, RAM or the keyboard port.
// It also forms the keyboard port read data. Assumes a synchronous
// active-low reset and one strobe per bus cycle.
module mmap_ctrl
    import mmap_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int LOW_WIN_AW = 14,
    parameter int TOP_WIN_AW = 13,
    parameter int KEY_ROWS   = 10,
    parameter int KEY_W      = 5,
    parameter int ROW_IDX_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      io_wr,
    input  logic [DATA_W-1:0]         io_wdata,
    input  logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_rd,
    input  logic                      mem_wr,
    input  logic [KEY_ROWS*KEY_W-1:0] key_rows,
    input  logic                      cas_in_neg,
    output logic                      rom_cs,
    output logic [LOW_WIN_AW-1:0]     rom_addr,
    output logic                      ram_cs,
    output logic                      ram_we,
    output logic [ADDR_W-1:0]         ram_addr,
    output logic                      kbd_sel,
    output logic [DATA_W-1:0]         kbd_rdata,
    output logic                      video_en,
    output logic                      cas_out_neg
);

    localparam int HI_W = ADDR_W - TOP_WIN_AW;

    ctrl_t   ctrl_q;
    region_e region;
    logic    low_bank;
    logic    top_bank;

    // Control register
    mmap_ctrl_reg #(
        .DATA_W (DATA_W)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (io_wr),
        .wdata  (io_wdata),
        .ctrl_q (ctrl_q)
    );

    // Bank and level fields seen by the decode and the outputs
    always_comb begin
        low_bank    = ctrl_q.low_ram;
        top_bank    = ctrl_q.top_kbd;
        video_en    = ctrl_q.video;
        cas_out_neg = ctrl_q.cas_neg;
    end

    // Address region
    mmap_region_dec #(
        .ADDR_W     (ADDR_W),
        .LOW_WIN_AW (LOW_WIN_AW),
        .TOP_WIN_AW (TOP_WIN_AW)
    ) u_dec (
        .addr_hi (mem_addr[ADDR_W-1 -: HI_W]),
        .region  (region)
    );

    // Target selects
    mmap_sel #(
        .ADDR_W (ADDR_W),
        .ROM_AW (LOW_WIN_AW)
    ) u_sel (
        .region   (region),
        .low_ram  (low_bank),
        .top_kbd  (top_bank),
        .rd       (mem_rd),
        .wr       (mem_wr),
        .addr     (mem_addr),
        .rom_cs   (rom_cs),
        .rom_addr (rom_addr),
        .ram_cs   (ram_cs),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .kbd_sel  (kbd_sel)
    );

    // Keyboard port read data
    mmap_kbd_port #(
        .KEY_ROWS  (KEY_ROWS),
        .KEY_W     (KEY_W),
        .ROW_IDX_W (ROW_IDX_W),
        .DATA_W    (DATA_W)
    ) u_kbd (
        .row_idx    (mem_addr[ROW_IDX_W-1:0]),
        .key_rows   (key_rows),
        .cas_in_neg (cas_in_neg),
        .rdata      (kbd_rdata)
    );

endmodule

// File: rtl/mmap_ctrl_chk.sv
// Module: mmap_ctrl_chk
// Assertion checker for mmap_ctrl. It is attached to the top module by the
// bind below and observes the ports and the stored bank bits.
module mmap_ctrl_chk #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int LOW_WIN_AW = 14,
    parameter int TOP_WIN_AW = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_wdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              rom_cs,
    input logic              ram_cs,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              kbd_sel,
    input logic              video_en,
    input logic              cas_out_neg,
    input logic              low_bank,
    input logic              top_bank
);

    localparam int LOW_TAGW = ADDR_W - LOW_WIN_AW;
    localparam int TOP_TAGW = ADDR_W - TOP_WIN_AW;

    logic in_low;
    logic in_top;

    // Window membership as seen from the bus
    always_comb begin
        in_low = (mem_addr[ADDR_W-1 -: LOW_TAGW] == '0);
        in_top = (mem_addr[ADDR_W-1 -: TOP_TAGW] == '1);
    end

    // R1 / R10: a control write shows up after its edge
    p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(io_wr) && $past(rst_n)) |->
            (video_en == $past(io_wdata[0]) && cas_out_neg == $past(io_wdata[3])));

    // R2: writes to the low window with ROM mapped reach no RAM
    p_rom_write_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_bank && in_low && mem_wr) |-> (!ram_cs && !ram_we));

    // R4: the middle region is always RAM at the CPU address
    p_mid_is_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_low && !in_top && (mem_rd || mem_wr)) |->
            (ram_cs && ram_addr == mem_addr && ram_we == mem_wr));

    // R6: writes to the keyboard window are discarded
    p_kbd_write_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (top_bank && in_top && mem_wr) |-> (!ram_cs && !ram_we));

    // R9: the first cycle after reset maps ROM low and RAM high
    p_reset_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> (!low_bank && !top_bank && !video_en && !cas_out_neg));

    // R11: selects are mutually exclusive
    p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, ram_cs, kbd_sel}));

    // R11: no select without a strobe
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd && !mem_wr) |-> (!rom_cs && !ram_cs && !kbd_sel));

endmodule

bind mmap_ctrl mmap_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LOW_WIN_AW (LOW_WIN_AW),
    .TOP_WIN_AW (TOP_WIN_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_wr       (io_wr),
    .io_wdata    (io_wdata),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .rom_cs      (rom_cs),
    .ram_cs      (ram_cs),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .kbd_sel     (kbd_sel),
    .video_en    (video_en),
    .cas_out_neg (cas_out_neg),
    .low_bank    (low_bank),
    .top_bank    (top_bank)
);

// File: tb/mmap_ctrl_tb_top.sv
// Bench for mmap_ctrl: full sweep of the bank states, address slices and
// bus cycles, plus every keyboard row index with both cassette polarities.
module mmap_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [15:0] mem_addr = '0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic [49:0] key_rows;
    logic        cas_in_neg = 1'b0;
    logic        rom_cs;
    logic [13:0] rom_addr;
    logic        ram_cs;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic        kbd_sel;
    logic [7:0]  kbd_rdata;
    logic        video_en;
    logic        cas_out_neg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mmap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_wdata(io_wdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .key_rows(key_rows), .cas_in_neg(cas_in_neg),
        .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_we(ram_we),
        .ram_addr(ram_addr), .kbd_sel(kbd_sel), .kbd_rdata(kbd_rdata),
        .video_en(video_en), .cas_out_neg(cas_out_neg)
    );

    function automatic logic [4:0] key_pat(input int r);
        return 5'((r * 7 + 3) & 31);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        io_wr = 1'b1;
        io_wdata = v;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus(input logic [15:0] a, input logic rd, input logic wr);
        @(negedge clk);
        mem_addr = a;
        mem_rd = rd;
        mem_wr = wr;
        #2;
    endtask

    initial begin
        for (int r = 0; r < 10; r++) key_rows[r*5 +: 5] = key_pat(r);
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        bus(16'h0123, 1, 0);
        check(rom_cs && !ram_cs, "R9", "low read after reset", {rom_cs, ram_cs}, 2'b10);
        bus(16'hF010, 1, 0);
        check(ram_cs && !kbd_sel, "R9", "top read after reset", {ram_cs, kbd_sel}, 2'b10);
        check(!video_en && !cas_out_neg, "R9", "levels after reset",
              {video_en, cas_out_neg}, 0);

        // R1 / R10: field load and one-edge latency
        bus(16'h0000, 0, 0);
        @(negedge clk);
        io_wr = 1'b1;
        io_wdata = 8'h09;
        #2;
        check(!video_en && !cas_out_neg, "R1", "before edge",
              {video_en, cas_out_neg}, 0);
        @(negedge clk);
        io_wr = 1'b0;
        #2;
        check(video_en, "R10", "video enable bit0", video_en, 1);
        check(cas_out_neg, "R10", "cassette level bit3", cas_out_neg, 1);
        wr_ctrl(8'h08);
        #2;
        check(!video_en && cas_out_neg, "R1", "bit0 cleared",
              {video_en, cas_out_neg}, 2'b01);
        wr_ctrl(8'h01);
        #2;
        check(video_en && !cas_out_neg, "R10", "bit3 cleared",
              {video_en, cas_out_neg}, 2'b10);

        // R2-R6, R11: sweep bank states x address slices x cycle kinds
        for (int bk = 0; bk < 4; bk++) begin
            wr_ctrl(8'((bk & 1) << 1 | ((bk >> 1) & 1) << 2));
            for (int nib = 0; nib < 16; nib++) begin
                for (int op = 0; op < 3; op++) begin
                    logic [15:0] a;
                    logic rd, wr, e_rom, e_ram, e_we, e_kbd, low, top;
                    string rq;
                    a = {4'(nib), 12'h5A3 ^ 12'(nib * 17)};
                    rd = (op == 1);
                    wr = (op == 2);
                    low = (a < 16'h4000);
                    top = (a >= 16'hE000);
                    e_rom = 0; e_ram = 0; e_we = 0; e_kbd = 0;
                    if (low && (bk & 1) == 0) begin
                        rq = "R2"; e_rom = rd;
                    end else if (low) begin
                        rq = "R3"; e_ram = rd | wr; e_we = wr;
                    end else if (top && (bk & 2) != 0) begin
                        rq = "R6"; e_kbd = rd;
                    end else if (top) begin
                        rq = "R5"; e_ram = rd | wr; e_we = wr;
                    end else begin
                        rq = "R4"; e_ram = rd | wr; e_we = wr;
                    end
                    if (op == 0) rq = "R11";
                    bus(a, rd, wr);
                    check({rom_cs, ram_cs, ram_we, kbd_sel} == {e_rom, e_ram, e_we, e_kbd},
                          rq, "selects", {rom_cs, ram_cs, ram_we, kbd_sel},
                          {e_rom, e_ram, e_we, e_kbd});
                    if (e_ram) check(ram_addr == a, rq, "ram_addr", ram_addr, a);
                    if (e_rom) check(rom_addr == a[13:0], rq, "rom_addr", rom_addr, a[13:0]);
                end
            end
        end

        // R7 / R8: keyboard port rows with both cassette polarities
        wr_ctrl(8'h04);
        for (int c = 0; c < 2; c++) begin
            cas_in_neg = c[0];
            for (int r = 0; r < 16; r++) begin
                logic [7:0] e;
                e = (r < 10) ? {c[0], 2'b00, key_pat(r)} : {c[0], 7'h1F};
                bus(16'hE000 | 16'(r) | 16'h0150, 1, 0);
                check(kbd_sel, "R6", "kbd select", kbd_sel, 1);
                check(kbd_rdata[6:0] == e[6:0], "R7", "row data", kbd_rdata[6:0], e[6:0]);
                check(kbd_rdata[7] == e[7], "R8", "cassette bit", kbd_rdata[7], e[7]);
            end
        end

        // R9: mid-run reset returns to ROM low / RAM high
        wr_ctrl(8'h0F);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus(16'h2000, 1, 0);
        check(rom_cs, "R9", "ROM after second reset", rom_cs, 1);
        bus(16'hE005, 1, 0);
        check(ram_cs && !kbd_sel, "R9", "RAM high after second reset",
              {ram_cs, kbd_sel}, 2'b10);

        bus(16'h0000, 0, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule